// File: doc/BRIEF.md
# Five-Source Interrupt Enable and Clear Controller

This block gathers interrupt events from five sources (external, timer 1, timer 2, asynchronous serial and synchronous serial) and turns them into one interrupt line for the host processor. Each source has an enable bit and a sticky pending latch. A one-cycle pulse from a source sets its latch, but only while that source is enabled. The latch then holds until the host clears it.

The host sees one 16-bit register whose meaning depends on the direction of access. A write carries two things at once. The low bits load the enables. The high bits are write-one-to-clear strobes for the pending latches. A read does not return what was written. It returns the pending latches. The interrupt line is high while any latch is both pending and enabled.

Top module: `irqc_top`

## Requirements
- R1: Reset clears every enable and every pending latch. While reset is low, rd_data and irq_out are zero. Reset takes effect at once and is released in step with the clock.
- R2: A write loads the enables from wr_data bits 4:0: bit 4 synchronous serial, bit 3 asynchronous serial, bit 2 timer 2, bit 1 timer 1, bit 0 external. An enabled source pulse at src_pulse bit i sets pending bit i, which appears on rd_data bit i after the next clock edge.
- R3: A pulse from a disabled source leaves its pending latch unchanged.
- R4: rd_data bits 4:0 show the pending latches, using the same bit order as the enables. rd_data bits 15:5 read as zero. The written enable value is never returned.
- R5: A write with wr_data bit 8+i set clears pending bit i (bit 12 synchronous serial, 11 asynchronous serial, 10 timer 2, 9 timer 1, 8 external). Other pending bits are not affected.
- R6: A clear bit written as 0 has no effect on its pending latch.
- R7: If an enabled source pulse and a clear of the same source fall in the same cycle, the latch ends up set.
- R8: irq_out is high exactly when some pending bit has its enable set. Dropping an enable masks irq_out, but the pending bit stays visible on rd_data.
- R9: A pending latch stays set, with no further pulses, until it is cleared or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pulse | input | 5 | One-cycle event per source (bit order as R2) |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Write word: enables in 4:0, clear strobes in 12:8 |
| rd_data | output | 16 | Pending latches in 4:0, zero above |
| irq_out | output | 1 | Combined interrupt to the host |

## Verification
The bench first applies a walking one on the source pulses with every source enabled. This shows that each pulse reaches its own pending bit and no other. It then pulses all sources under a partial enable mask, which separates gated sources from ungated ones. Walking clear bits with all latches set show that the clear strobes map bit 8+i to source i, and a clear word with bit 8 at zero shows that zeros are inert. Two further cases check precedence and masking: a pulse and a clear of the same source in one cycle, and an enable dropped while a latch is pending. These tell the set-over-clear rule apart from clear-over-set, and separate irq_out masking from the latch itself.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned IRQC_NUM_SRC = 5;
  localparam int unsigned IRQC_REG_W   = 16;
  localparam int unsigned IRQC_CLR_LSB = 8;

  typedef enum logic [2:0] {
    SRC_EXT   = 3'd0,
    SRC_TIM1  = 3'd1,
    SRC_TIM2  = 3'd2,
    SRC_ASYNC = 3'd3,
    SRC_SYNC  = 3'd4
  } irqc_src_e;
endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) shift_q <= '0;
    else         shift_q <= shift_d;
  end

  assign rst_sync_no = shift_q[STAGES-1];
endmodule

// File: rtl/irqc_enable_reg.sv
module irqc_enable_reg #(
  parameter int unsigned NUM_SRC = 5
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic               wr_en,
  input  logic [NUM_SRC-1:0] wr_en_bits,
  output logic [NUM_SRC-1:0] en_q
);
  logic [NUM_SRC-1:0] en_d;

  always_comb begin
    en_d = en_q;
    if (wr_en) en_d = wr_en_bits;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)    en_q <= '0;
    else if (wr_en) en_q <= en_d;
  end

  AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_en |=> (en_q == $past(wr_en_bits))); // R2
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    !wr_en |=> $stable(en_q)); // R2
endmodule

// File: rtl/irqc_pend_cell.sv
module irqc_pend_cell (
  input  logic clk,
  input  logic rst_ni,
  input  logic src_pulse,
  input  logic src_en,
  input  logic clr_strobe,
  output logic pend_q
);
  logic set_evt;
  logic upd_en;
  logic pend_d;

  assign set_evt = src_pulse & src_en;
  assign upd_en  = set_evt | clr_strobe;

  always_comb begin
    pend_d = pend_q;
    if (set_evt)         pend_d = 1'b1;
    else if (clr_strobe) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (upd_en) pend_q <= pend_d;
  end

  AST_SET_WHEN_EN: assert property (@(posedge clk) disable iff (!rst_ni)
    (src_pulse && src_en) |=> pend_q); // R2
  AST_NO_SET_WHEN_DIS: assert property (@(posedge clk) disable iff (!rst_ni)
    (!pend_q && !(src_pulse && src_en)) |=> !pend_q); // R3
  AST_CLEAR_W1C: assert property (@(posedge clk) disable iff (!rst_ni)
    (clr_strobe && !(src_pulse && src_en)) |=> !pend_q); // R5
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_ni)
    (pend_q && !clr_strobe) |=> pend_q); // R9
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_ni)
    (clr_strobe && src_pulse && src_en) |=> pend_q); // R7
endmodule

// File: rtl/irqc_combine.sv
module irqc_combine #(
  parameter int unsigned NUM_SRC = 5
) (
  input  logic [NUM_SRC-1:0] pend,
  input  logic [NUM_SRC-1:0] en,
  output logic               irq
);
  logic [NUM_SRC-1:0] live;

  always_comb begin
    live = pend & en;
    irq  = |live;
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_SRC     = IRQC_NUM_SRC,
  parameter int unsigned REG_W       = IRQC_REG_W,
  parameter int unsigned CLR_LSB     = IRQC_CLR_LSB,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_pulse,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_data,
  output logic [REG_W-1:0]   rd_data,
  output logic               irq_out
);
  localparam int unsigned CLR_MSB = CLR_LSB + NUM_SRC - 1;
  localparam int unsigned PAD_W   = REG_W - NUM_SRC;

  logic               rst_int_n;
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] clr_vec;
  logic [NUM_SRC-1:0] pend_vec;
  logic               unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[REG_W-1:CLR_MSB+1], wr_data[CLR_LSB-1:NUM_SRC]};

  irqc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_ni     (rst_n),
    .rst_sync_no(rst_int_n)
  );

  irqc_enable_reg #(.NUM_SRC(NUM_SRC)) u_en_reg (
    .clk       (clk),
    .rst_ni    (rst_int_n),
    .wr_en     (wr_en),
    .wr_en_bits(wr_data[NUM_SRC-1:0]),
    .en_q      (en_q)
  );

  assign clr_vec = wr_en ? wr_data[CLR_MSB:CLR_LSB] : '0;

  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_pend
    irqc_pend_cell u_cell (
      .clk       (clk),
      .rst_ni    (rst_int_n),
      .src_pulse (src_pulse[gi]),
      .src_en    (en_q[gi]),
      .clr_strobe(clr_vec[gi]),
      .pend_q    (pend_vec[gi])
    );
  end

  irqc_combine #(.NUM_SRC(NUM_SRC)) u_combine (
    .pend(pend_vec),
    .en  (en_q),
    .irq (irq_out)
  );

  assign rd_data = {{PAD_W{1'b0}}, pend_vec};

  AST_IRQ_NEEDS_LIVE: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_out |-> ((rd_data[NUM_SRC-1:0] & en_q) != '0)); // R8
  AST_LIVE_GIVES_IRQ: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((rd_data[NUM_SRC-1:0] & en_q) != '0) |-> irq_out); // R8
  AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_data[REG_W-1:NUM_SRC] == '0); // R4
  AST_RST_IDLE: assert property (@(posedge clk)
    !rst_int_n |-> (rd_data == '0 && !irq_out)); // R1
endmodule

// File: tb/irqc_top_bench.sv
module irqc_top_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  src_pulse;
  logic        wr_en;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irqc_top u_irqc_top (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    src_pulse = '0;
    wr_en     = 1'b0;
    wr_data   = '0;
  endtask

  task automatic wr(input logic [15:0] d);
    wr_en = 1'b1; wr_data = d; cyc();
  endtask

  task automatic pulse(input logic [4:0] m);
    src_pulse = m; cyc();
  endtask

  task automatic t_reset();
    check("R1 rd after reset", rd_data, 16'h0000);
    check("R1 irq after reset", {15'b0, irq_out}, 16'h0000);
  endtask

  task automatic t_read_is_pending();
    wr(16'h001F);
    check("R4 read shows pending not enables", rd_data, 16'h0000);
    check("R8 no irq with nothing pending", {15'b0, irq_out}, 16'h0000);
  endtask

  task automatic t_walk_set();
    logic [4:0] acc = '0;
    for (int i = 0; i < 5; i++) begin
      pulse(5'b1 << i);
      acc |= 5'b1 << i;
      check("R2 walking set", rd_data, {11'b0, acc});
      check("R8 irq with live pending", {15'b0, irq_out}, 16'h0001);
    end
  endtask

  task automatic t_walk_clear();
    logic [4:0] acc = 5'h1F;
    for (int i = 0; i < 5; i++) begin
      wr(16'h001F | (16'h0100 << i));
      acc &= ~(5'b1 << i);
      check("R5 walking clear", rd_data, {11'b0, acc});
    end
    check("R8 irq low after all cleared", {15'b0, irq_out}, 16'h0000);
  endtask

  task automatic t_disabled();
    wr(16'h0005);
    pulse(5'h1F);
    check("R3 only enabled sources latch", rd_data, 16'h0005);
    wr(16'h1F05);
    check("R5 clear all", rd_data, 16'h0000);
  endtask

  task automatic t_zero_clear();
    wr(16'h001F);
    pulse(5'h1F);
    wr(16'h1E1F);
    check("R6 zero clear bit leaves external", rd_data, 16'h0001);
    wr(16'h001F);
    check("R6 no clear bits leave latch", rd_data, 16'h0001);
  endtask

  task automatic t_event_wins();
    wr(16'h1F1F);
    check("R5 precondition cleared", rd_data, 16'h0000);
    src_pulse = 5'b00100; wr_en = 1'b1; wr_data = 16'h041F; cyc();
    check("R7 pulse beats clear", rd_data, 16'h0004);
  endtask

  task automatic t_mask_and_sticky();
    wr(16'h1F1F);
    pulse(5'b00001);
    wr(16'h0000);
    check("R8 pending kept when disabled", rd_data, 16'h0001);
    check("R8 irq masked", {15'b0, irq_out}, 16'h0000);
    for (int i = 0; i < 10; i++) cyc();
    check("R9 latch sticky", rd_data, 16'h0001);
    wr(16'h0001);
    check("R8 irq back on re-enable", {15'b0, irq_out}, 16'h0001);
  endtask

  task automatic t_async_reset();
    pulse(5'b00001);
    #1 rst_n = 1'b0;
    #0.5;
    check("R1 async clear of pending", rd_data, 16'h0000);
    check("R1 async irq low", {15'b0, irq_out}, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) cyc();
    pulse(5'h1F);
    check("R1 enables cleared by reset", rd_data, 16'h0000);
  endtask

  initial begin
    rst_n = 1'b0; src_pulse = '0; wr_en = 1'b0; wr_data = '0;
    #0.1;
    check("R1 rd during reset", rd_data, 16'h0000);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) cyc();
    t_reset();
    t_read_is_pending();
    t_walk_set();
    t_walk_clear();
    t_disabled();
    t_zero_clear();
    t_event_wins();
    t_mask_and_sticky();
    t_async_reset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule